// File: doc/BRIEF.md
# Operand Specifier Byte Parser

This block decodes one variable-length operand specifier from a byte stream. The stream delivers one byte per cycle over a valid/ready handshake. The first byte is one of three kinds: a short literal, selected by its two top bits; an index prefix, which records an index register and restarts the parse on a base specifier; or a head byte that holds a mode nibble and a register number. Some head modes are followed by one, two or four displacement bytes. These bytes arrive least significant first, and the block sign-extends them to 32 bits.

When the last byte of a specifier has been taken, the block raises a single-cycle done strobe. With it come the mode, the register, the index register, the literal or displacement value, the total byte count and an illegal flag. These outputs are registered and hold until the next specifier begins. An upstream decoder uses them to drive address generation. This block performs no address arithmetic and no memory access.

Top module: `opspec_parser`

## Requirements
- R1: A first byte whose bits [7:6] are 00 is a short literal. Done follows that single byte, with specLiteral=1, specIndexed=0, specValue equal to bits [5:0] zero-extended, and specLength=1.
- R2: A head byte whose upper nibble is 0101 through 1001 completes with no further bytes. specMode holds bits [7:4], specReg holds bits [3:0], specValue is 0 and the length counts the head byte.
- R3: Head nibbles 1010 and 1011 take one displacement byte, sign-extended to 32 bits on specValue.
- R4: Head nibbles 1100 and 1101 take two displacement bytes. The first byte is the low byte, and the result is sign-extended from bit 15.
- R5: Head nibbles 1110 and 1111 take four displacement bytes, least significant byte first.
- R6: Upper nibble 0100 is an index prefix. specIndexed=1 and indexReg takes bits [3:0]. A base specifier follows and is parsed as in R2 to R5, and specLength includes the prefix byte.
- R7: An index prefix followed by a literal byte or by a second index prefix ends the parse at once, with specIllegal=1 and specLength=2.
- R8: A byte is consumed only in a cycle where byteValid and byteReady are both high. Data presented while byteValid is low has no effect on the result.
- R9: specDone is high for exactly one cycle, in the cycle after the final byte is accepted. byteReady is low in that cycle and high again in the next, ready for a new specifier.
- R10: After reset, specDone is 0 and byteReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Stream byte present |
| byteData | input | 8 | Stream byte |
| byteReady | output | 1 | Parser can take a byte |
| specDone | output | 1 | One-cycle strobe: specifier complete |
| specIllegal | output | 1 | Specifier is malformed |
| specLiteral | output | 1 | Specifier is a short literal |
| specIndexed | output | 1 | Specifier had an index prefix |
| specMode | output | 4 | Mode nibble of the (base) head byte |
| specReg | output | 4 | Register number of the (base) head byte |
| indexReg | output | 4 | Index register from the prefix |
| specValue | output | 32 | Literal or sign-extended displacement |
| specLength | output | 3 | Total bytes in the specifier |

## Verification
Some properties are checked by assertions on every cycle. The done strobe never lasts two cycles. The state holds whenever no byte is offered. A completed literal always reports length 1, an illegal specifier always reports length 2, and an indexed result is never shorter than two bytes. Only the bench's scenarios can show the rest. That covers the displacement byte order and sign extension for each width, the capture of the index register across a restart, and the fact that bytes presented during valid-low gaps leave the decoded fields unchanged.

// File: rtl/opspec_pkg.sv
package opspec_pkg;
  localparam int BYTE_W   = 8;
  localparam int VALUE_W  = 32;
  localparam int NBYTES   = VALUE_W / BYTE_W;
  localparam int DPOS_W   = $clog2(NBYTES);
  localparam int REM_W    = $clog2(NBYTES + 1);
  localparam int LEN_W    = $clog2(NBYTES + 3);
  localparam logic [3:0] IDX_NIB = 4'b0100;

  typedef enum logic [1:0] {ST_IDLE, ST_BASE, ST_DISP, ST_DONE} parseState_t;

  typedef struct packed {
    logic clear;
    logic count;
    logic headLoad;
    logic idxLoad;
    logic dispLoad;
    logic flagIll;
  } opStrobes_t;

  function automatic logic [REM_W-1:0] dispBytes(input logic [3:0] nib);
    case (nib[3:1])
      3'b101:  return REM_W'(1);
      3'b110:  return REM_W'(2);
      3'b111:  return REM_W'(NBYTES);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/opspec_ctrl.sv
module opspec_ctrl
  import opspec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output logic              byteReady,
  output logic              specDone,
  output opStrobes_t        strobes
);
  parseState_t state, stateNext;
  logic [REM_W-1:0] remain, remainNext;
  logic accept, isLit, isIdx;

  assign byteReady = (state != ST_DONE);
  assign specDone  = (state == ST_DONE);
  assign accept    = byteValid && byteReady;
  assign isLit     = (byteData[7:6] == 2'b00);
  assign isIdx     = (byteData[7:4] == IDX_NIB);

  always_comb begin
    stateNext  = state;
    remainNext = remain;
    strobes    = '0;
    case (state)
      ST_IDLE, ST_BASE: if (accept) begin
        strobes.count = 1'b1;
        strobes.clear = (state == ST_IDLE);
        if (state == ST_BASE && (isLit || isIdx)) begin
          strobes.flagIll = 1'b1;
          stateNext = ST_DONE;
        end else if (isIdx) begin
          strobes.idxLoad = 1'b1;
          stateNext = ST_BASE;
        end else begin
          strobes.headLoad = 1'b1;
          remainNext = isLit ? '0 : dispBytes(byteData[7:4]);
          stateNext  = (remainNext == '0) ? ST_DONE : ST_DISP;
        end
      end
      ST_DISP: if (accept) begin
        strobes.count    = 1'b1;
        strobes.dispLoad = 1'b1;
        remainNext = remain - 1'b1;
        if (remain == REM_W'(1)) stateNext = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else begin
      state  <= stateNext;
      remain <= remainNext;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    specDone |=> !specDone);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid && state != ST_DONE) |=> (state == $past(state)));
endmodule

// File: rtl/opspec_dpath.sv
module opspec_dpath
  import opspec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [BYTE_W-1:0]  byteData,
  input  opStrobes_t         strobes,
  input  logic               specDone,
  output logic               specIllegal,
  output logic               specLiteral,
  output logic               specIndexed,
  output logic [3:0]         specMode,
  output logic [3:0]         specReg,
  output logic [3:0]         indexReg,
  output logic [VALUE_W-1:0] specValue,
  output logic [LEN_W-1:0]   specLength
);
  logic [DPOS_W-1:0]  dispPos;
  logic [VALUE_W-1:0] dispNext;

  // place the byte at its lane and fill every higher lane with its sign
  always_comb begin
    dispNext = specValue;
    for (int j = 0; j < NBYTES; j++) begin
      if (DPOS_W'(j) == dispPos)
        dispNext[j*BYTE_W +: BYTE_W] = byteData;
      else if (DPOS_W'(j) > dispPos)
        dispNext[j*BYTE_W +: BYTE_W] = {BYTE_W{byteData[BYTE_W-1]}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      specIllegal <= 1'b0;
      specLiteral <= 1'b0;
      specIndexed <= 1'b0;
      specMode    <= '0;
      specReg     <= '0;
      indexReg    <= '0;
      specValue   <= '0;
      specLength  <= '0;
      dispPos     <= '0;
    end else begin
      if (strobes.clear) begin
        specIllegal <= 1'b0;
        specLiteral <= 1'b0;
        specIndexed <= 1'b0;
        specMode    <= '0;
        specReg     <= '0;
        indexReg    <= '0;
        specValue   <= '0;
        dispPos     <= '0;
      end
      if (strobes.count)
        specLength <= strobes.clear ? LEN_W'(1) : specLength + 1'b1;
      if (strobes.idxLoad) begin
        specIndexed <= 1'b1;
        indexReg    <= byteData[3:0];
      end
      if (strobes.headLoad) begin
        specMode    <= byteData[7:4];
        specReg     <= byteData[3:0];
        specLiteral <= (byteData[7:6] == 2'b00);
        specValue   <= (byteData[7:6] == 2'b00) ? VALUE_W'(byteData[5:0]) : '0;
      end
      if (strobes.dispLoad) begin
        specValue <= dispNext;
        dispPos   <= dispPos + 1'b1;
      end
      if (strobes.flagIll) specIllegal <= 1'b1;
    end
  end

  // R1
  literal_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (specDone && specLiteral) |-> (specLength == LEN_W'(1)));

  // R7
  illegal_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (specDone && specIllegal) |-> (specLength == LEN_W'(2)));

  // R6
  indexed_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (specDone && specIndexed) |-> (specLength >= LEN_W'(2)));
endmodule

// File: rtl/opspec_parser.sv
module opspec_parser
  import opspec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         byteValid,
  input  logic [7:0]   byteData,
  output logic         byteReady,
  output logic         specDone,
  output logic         specIllegal,
  output logic         specLiteral,
  output logic         specIndexed,
  output logic [3:0]   specMode,
  output logic [3:0]   specReg,
  output logic [3:0]   indexReg,
  output logic [31:0]  specValue,
  output logic [2:0]   specLength
);
  opStrobes_t strobes;

  opspec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .specDone(specDone), .strobes(strobes)
  );

  opspec_dpath u_dpath (
    .clk(clk), .rstN(rstN), .byteData(byteData), .strobes(strobes),
    .specDone(specDone), .specIllegal(specIllegal), .specLiteral(specLiteral),
    .specIndexed(specIndexed), .specMode(specMode), .specReg(specReg),
    .indexReg(indexReg), .specValue(specValue), .specLength(specLength)
  );
endmodule

// File: tb/sim_opspec_parser.sv
module sim_opspec_parser;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic byteReady, specDone, specIllegal, specLiteral, specIndexed;
  logic [3:0] specMode, specReg, indexReg;
  logic [31:0] specValue;
  logic [2:0] specLength;

  int checkCount = 0;
  int failCount = 0;
  logic [7:0] sb [6];

  always #10 clk = ~clk;

  opspec_parser u0 (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .specDone(specDone), .specIllegal(specIllegal),
    .specLiteral(specLiteral), .specIndexed(specIndexed), .specMode(specMode),
    .specReg(specReg), .indexReg(indexReg), .specValue(specValue),
    .specLength(specLength)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // independent model of the specifier rules
  task automatic model(output bit eLit, output bit eIdx, output bit eIll,
                       output logic [3:0] eMode, output logic [3:0] eReg,
                       output logic [3:0] eIdxReg, output logic [31:0] eVal,
                       output int eLen);
    int p = 0;
    int nb = 0;
    logic [63:0] v = '0;
    logic [7:0] h;
    eLit = 0; eIdx = 0; eIll = 0; eMode = 0; eReg = 0; eIdxReg = 0; eVal = 0;
    if (sb[0][7:4] == 4'h4) begin
      eIdx = 1; eIdxReg = sb[0][3:0]; p = 1;
      if (sb[1][7:6] == 2'b00 || sb[1][7:4] == 4'h4) begin
        eIll = 1; eLen = 2; return;
      end
    end
    h = sb[p];
    if (h[7:6] == 2'b00) begin
      eLit = 1; eVal = {26'd0, h[5:0]}; eLen = p + 1; return;
    end
    eMode = h[7:4]; eReg = h[3:0];
    if (h[7:4] >= 4'hA && h[7:4] <= 4'hB) nb = 1;
    else if (h[7:4] >= 4'hC && h[7:4] <= 4'hD) nb = 2;
    else if (h[7:4] >= 4'hE) nb = 4;
    for (int k = 0; k < nb; k++) v = v | (64'(sb[p+1+k]) << (8*k));
    if (nb > 0 && v[8*nb-1]) v = v | ~((64'd1 << (8*nb)) - 1);
    eVal = v[31:0];
    eLen = p + 1 + nb;
  endtask

  task automatic sendAndCheck(input int maxGap, input string tag);
    bit eLit, eIdx, eIll;
    logic [3:0] eMode, eReg, eIdxReg;
    logic [31:0] eVal;
    int eLen;
    model(eLit, eIdx, eIll, eMode, eReg, eIdxReg, eVal, eLen);
    for (int i = 0; i < eLen; i++) begin
      for (int g = $urandom_range(0, maxGap); g > 0; g--) begin
        byteValid = 1'b0; byteData = 8'($urandom);
        @(negedge clk);
      end
      while (!byteReady) @(negedge clk);
      if (i > 0) chk(!specDone, "R9", {tag, " early done"}, 32'(specDone), 0);
      byteValid = 1'b1; byteData = sb[i];
      @(negedge clk);
    end
    byteValid = 1'b0; byteData = 8'($urandom);
    chk(specDone, "R9", {tag, " done"}, 32'(specDone), 1);
    chk(!byteReady, "R9", {tag, " ready low"}, 32'(byteReady), 0);
    chk(specLength == 3'(eLen), eIll ? "R7" : (eIdx ? "R6" : "R2"),
        {tag, " length"}, 32'(specLength), 32'(eLen));
    chk(specIllegal == eIll, "R7", {tag, " illegal"}, 32'(specIllegal), 32'(eIll));
    chk(specIndexed == eIdx, "R6", {tag, " indexed"}, 32'(specIndexed), 32'(eIdx));
    if (eIdx) chk(indexReg == eIdxReg, "R6", {tag, " indexReg"}, 32'(indexReg), 32'(eIdxReg));
    if (!eIll) begin
      chk(specLiteral == eLit, "R1", {tag, " literal"}, 32'(specLiteral), 32'(eLit));
      chk(specValue == eVal, eLit ? "R1" : "R3", {tag, " value"}, specValue, eVal);
      if (!eLit) begin
        chk(specMode == eMode, "R2", {tag, " mode"}, 32'(specMode), 32'(eMode));
        chk(specReg == eReg, "R2", {tag, " reg"}, 32'(specReg), 32'(eReg));
      end
    end
    @(negedge clk);
    chk(!specDone && byteReady, "R9", {tag, " pulse end"}, 32'({specDone, byteReady}), 32'b01);
  endtask

  task automatic setBytes(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                          input logic [7:0] b3, input logic [7:0] b4, input logic [7:0] b5);
    sb[0] = b0; sb[1] = b1; sb[2] = b2; sb[3] = b3; sb[4] = b4; sb[5] = b5;
  endtask

  function automatic logic [7:0] randHead(input int cls);
    case (cls)
      0: return {2'b00, 6'($urandom)};
      1: return {4'($urandom_range(5, 9)), 4'($urandom)};
      default: return {4'($urandom_range(10, 15)), 4'($urandom)};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10
    chk(!specDone && byteReady, "R10", "reset state", 32'({specDone, byteReady}), 32'b01);

    setBytes(8'h3F, 0, 0, 0, 0, 0);             sendAndCheck(0, "R1 literal max");
    setBytes(8'h5A, 0, 0, 0, 0, 0);             sendAndCheck(0, "R2 reg mode");
    setBytes(8'hA3, 8'h80, 0, 0, 0, 0);         sendAndCheck(0, "R3 disp8 neg");
    setBytes(8'hC1, 8'h34, 8'h12, 0, 0, 0);     sendAndCheck(0, "R4 disp16");
    setBytes(8'hD1, 8'h00, 8'h90, 0, 0, 0);     sendAndCheck(0, "R4 disp16 neg");
    setBytes(8'hE2, 8'h78, 8'h56, 8'h34, 8'hF2, 0); sendAndCheck(0, "R5 disp32");
    setBytes(8'h47, 8'hA2, 8'h7F, 0, 0, 0);     sendAndCheck(0, "R6 indexed");
    setBytes(8'h4F, 8'hE1, 8'h01, 8'h02, 8'h03, 8'h84); sendAndCheck(0, "R6 max length");
    setBytes(8'h43, 8'h45, 0, 0, 0, 0);         sendAndCheck(0, "R7 double index");
    setBytes(8'h43, 8'h15, 0, 0, 0, 0);         sendAndCheck(0, "R7 index literal");
    setBytes(8'hC1, 8'hFF, 8'h7F, 0, 0, 0);     sendAndCheck(3, "R8 gaps");

    for (int n = 0; n < 400; n++) begin
      int cls;
      for (int i = 0; i < 6; i++) sb[i] = 8'($urandom);
      cls = $urandom_range(0, 4);
      if (cls < 3) sb[0] = randHead(cls);
      else begin
        sb[0] = {4'h4, 4'($urandom)};
        sb[1] = (cls == 3) ? randHead($urandom_range(1, 2))
                           : (($urandom_range(0, 1) == 0) ? randHead(0) : {4'h4, 4'($urandom)});
      end
      sendAndCheck(2, "random R3 R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule